// File: doc/BRIEF.md
# Flash Command Sequence Decoder

The decoder sits on the processor bus in front of one flash array. It watches byte writes addressed to that array and recognizes the multi-byte command sequences that the array accepts. Every normal sequence begins with a fixed pair of unlock writes, followed by a command byte. Some commands then need more bytes before anything starts. When a sequence is complete and correct, the decoder emits a single-cycle start pulse. It also holds the target address and data for the cell-level engine that carries out the work.

The decoder handles five kinds of request: a byte program, a shortcut mode that skips the unlock pair for repeated programs, a whole-array erase, a sector erase that can be paused and continued, and an explicit return to read mode. A write that breaks a sequence drops the partial sequence, and so does too long a pause between two bytes. In either case the array falls back to behaving like ROM. The cell-level engine reports completion through a single `op_done` input.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `read_mode` is 1, `bypass_on` is 0 and all five start pulses are 0.
- R2: Unlock and command addresses are matched on address bits 11:0 only, and bits 15:12 may hold any value.
- R3: The sequence AAh@x555, 55h@xAAA, A0h@x555, followed by one write (A, D), gives `prog_go` high for one cycle. Then `op_addr`=A, `op_data`=D and `read_mode`=0.
- R4: Any of the following during a sequence returns the decoder to read mode with no start pulse: a wrong unlock byte, a wrong unlock address, or an unknown command byte. Later bytes of the broken sequence are then ignored.
- R5: A write with `arr_sel` low is not a sequence byte and changes nothing.
- R6: A sequence survives exactly 80 `us_tick` pulses between two accepted bytes, and the 81st tick aborts it to read mode. The tick counter does not run in read mode, while an operation is running, or while waiting in bypass mode.
- R7: Unlock, 80h@x555, unlock, then 10h@x555 gives one `chip_erase_go` pulse.
- R8: Unlock, 80h@x555, unlock, then 30h at address S gives one `sect_erase_go` pulse, and `op_addr`=S. `op_addr` changes only when a program or sector erase starts.
- R9: During a sector erase, writing B0h gives `suspend_go` and `read_mode`=1. While suspended, writing 30h gives `resume_go` and `read_mode`=0. Other writes during a suspend or a running erase are ignored, and B0h during a whole-array erase does nothing.
- R10: `op_done` ends a running operation. The decoder returns to read mode, or to bypass mode if the program was issued from bypass.
- R11: Unlock then 20h@x555 sets `bypass_on`=1. In bypass, A0h followed by one write (A, D) starts a program. 90h followed by 00h leaves bypass and returns to read mode.
- R12: Unlock then F0h@x555 returns to read mode with no start pulse.
- R13: At most one start pulse is high in any cycle, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data byte |
| arr_sel | input | 1 | This array is selected by the address decode |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| op_done | input | 1 | Running program or erase has finished |
| prog_go | output | 1 | Start a byte program |
| chip_erase_go | output | 1 | Start a whole-array erase |
| sect_erase_go | output | 1 | Start a sector erase |
| suspend_go | output | 1 | Pause the running sector erase |
| resume_go | output | 1 | Continue the paused sector erase |
| op_addr | output | 16 | Program or sector address |
| op_data | output | 8 | Program data |
| read_mode | output | 1 | Array reads like ROM |
| bypass_on | output | 1 | Unlock-bypass mode active |

## Verification
Every output is registered on, or decoded from, the state register at the same edge that samples the final write of a sequence. A start pulse, the captured address and data, and the new `read_mode` are therefore all due one clock after that write and last exactly that one cycle. The bench drives inputs on the falling edge and checks pulse values and mode flags on the falling edge right after the write, so it sees exactly that cycle. Pulse counts are taken from rising-edge counters, and the bench compares them only after two idle cycles, once any pulse has retired. Timeout checks count whole tick pulses after the last accepted byte: 80 ticks must leave the sequence alive, and 81 must end it.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int MATCH_W = 12;

    localparam logic [MATCH_W-1:0] ADR_FIRST  = 12'h555;
    localparam logic [MATCH_W-1:0] ADR_SECOND = 12'hAAA;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_BYPASS  = 8'h20;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESUME  = 8'h30;
    localparam logic [7:0] CMD_BYP_X1  = 8'h90;
    localparam logic [7:0] CMD_BYP_X2  = 8'h00;

    typedef enum logic [3:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_PGM_DATA,
        ST_ERS_A, ST_ERS_B, ST_ERS_CMD,
        ST_BYP_IDLE, ST_BYP_PGM, ST_BYP_EXIT,
        ST_BUSY_PGM, ST_BUSY_CHIP, ST_BUSY_SECT, ST_SUSP
    } fcd_state_e;

    typedef struct packed {
        logic prog;
        logic chip;
        logic sect;
        logic susp;
        logic resm;
    } fcd_go_t;

    function automatic logic key_hit(input logic [MATCH_W-1:0] lo_addr,
                                     input logic [7:0] data,
                                     input logic [MATCH_W-1:0] want_addr,
                                     input logic [7:0] want_data);
        return (lo_addr == want_addr) && (data == want_data);
    endfunction

    function automatic logic in_sequence(input fcd_state_e s);
        return s inside {ST_UNL1, ST_UNL2, ST_PGM_DATA, ST_ERS_A, ST_ERS_B,
                         ST_ERS_CMD, ST_BYP_PGM, ST_BYP_EXIT};
    endfunction

    function automatic logic is_busy(input fcd_state_e s);
        return s inside {ST_BUSY_PGM, ST_BUSY_CHIP, ST_BUSY_SECT};
    endfunction

endpackage

// File: rtl/fcd_gap_timer.sv
module fcd_gap_timer #(
    parameter int LIMIT = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            cnt <= '0;
        else if (tick && cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    assign expire = run && !restart && tick && (cnt == LIM);
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_acc,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              op_done,
    input  logic              expire,
    output fcd_state_e        state,
    output fcd_go_t           go,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              byp
);
    fcd_state_e        nxt;
    fcd_go_t           go_n;
    logic              cap_a, cap_d, byp_n;
    logic [MATCH_W-1:0] lo;
    logic              u1, u2, at_first;

    assign lo       = wr_addr[MATCH_W-1:0];
    assign u1       = key_hit(lo, wr_data, ADR_FIRST, KEY_FIRST);
    assign u2       = key_hit(lo, wr_data, ADR_SECOND, KEY_SECOND);
    assign at_first = (lo == ADR_FIRST);

    always_comb begin
        nxt   = state;
        go_n  = '0;
        cap_a = 1'b0;
        cap_d = 1'b0;
        if (op_done && is_busy(state)) begin
            nxt = (state == ST_BUSY_PGM && byp) ? ST_BYP_IDLE : ST_READ;
        end else if (wr_acc) begin
            unique case (state)
                ST_READ:     if (u1) nxt = ST_UNL1;
                ST_UNL1:     nxt = u2 ? ST_UNL2 : ST_READ;
                ST_UNL2: begin
                    nxt = ST_READ;
                    if (at_first) begin
                        if (wr_data == CMD_PROGRAM)     nxt = ST_PGM_DATA;
                        else if (wr_data == CMD_BYPASS) nxt = ST_BYP_IDLE;
                        else if (wr_data == CMD_ERASE)  nxt = ST_ERS_A;
                    end
                end
                ST_PGM_DATA, ST_BYP_PGM: begin
                    nxt     = ST_BUSY_PGM;
                    go_n.prog = 1'b1;
                    cap_a   = 1'b1;
                    cap_d   = 1'b1;
                end
                ST_ERS_A:    nxt = u1 ? ST_ERS_B : ST_READ;
                ST_ERS_B:    nxt = u2 ? ST_ERS_CMD : ST_READ;
                ST_ERS_CMD: begin
                    nxt = ST_READ;
                    if (wr_data == CMD_CHIP && at_first) begin
                        nxt       = ST_BUSY_CHIP;
                        go_n.chip = 1'b1;
                    end else if (wr_data == CMD_SECTOR) begin
                        nxt       = ST_BUSY_SECT;
                        go_n.sect = 1'b1;
                        cap_a     = 1'b1;
                    end
                end
                ST_BYP_IDLE: begin
                    if (wr_data == CMD_PROGRAM)      nxt = ST_BYP_PGM;
                    else if (wr_data == CMD_BYP_X1)  nxt = ST_BYP_EXIT;
                    else                             nxt = ST_READ;
                end
                ST_BYP_EXIT: nxt = ST_READ;
                ST_BUSY_SECT: begin
                    if (wr_data == CMD_SUSPEND) begin
                        nxt       = ST_SUSP;
                        go_n.susp = 1'b1;
                    end
                end
                ST_SUSP: begin
                    if (wr_data == CMD_RESUME) begin
                        nxt       = ST_BUSY_SECT;
                        go_n.resm = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (expire) begin
            nxt = ST_READ;
        end
        if (nxt == ST_BYP_IDLE)  byp_n = 1'b1;
        else if (nxt == ST_READ) byp_n = 1'b0;
        else                     byp_n = byp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_READ;
            go      <= '0;
            op_addr <= '0;
            op_data <= '0;
            byp     <= 1'b0;
        end else begin
            state <= nxt;
            go    <= go_n;
            byp   <= byp_n;
            if (cap_a) op_addr <= wr_addr;
            if (cap_d) op_data <= wr_data;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int TIMEOUT_US = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              arr_sel,
    input  logic              us_tick,
    input  logic              op_done,
    output logic              prog_go,
    output logic              chip_erase_go,
    output logic              sect_erase_go,
    output logic              suspend_go,
    output logic              resume_go,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              read_mode,
    output logic              bypass_on
);
    fcd_state_e state;
    fcd_go_t    go;
    logic       wr_acc, expire;

    assign wr_acc = wr_en && arr_sel;

    fcd_gap_timer #(.LIMIT(TIMEOUT_US)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (in_sequence(state)),
        .restart (wr_acc),
        .tick    (us_tick),
        .expire  (expire)
    );

    fcd_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .wr_acc  (wr_acc),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .op_done (op_done),
        .expire  (expire),
        .state   (state),
        .go      (go),
        .op_addr (op_addr),
        .op_data (op_data),
        .byp     (bypass_on)
    );

    assign prog_go       = go.prog;
    assign chip_erase_go = go.chip;
    assign sect_erase_go = go.sect;
    assign suspend_go    = go.susp;
    assign resume_go     = go.resm;
    assign read_mode     = (state == ST_READ) || (state == ST_SUSP);
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              arr_sel,
    input logic              prog_go,
    input logic              chip_erase_go,
    input logic              sect_erase_go,
    input logic              suspend_go,
    input logic              resume_go,
    input logic [ADDR_W-1:0] op_addr,
    input logic              read_mode,
    input logic              bypass_on
);
    logic [4:0] gos;
    assign gos = {prog_go, chip_erase_go, sect_erase_go, suspend_go, resume_go};

    AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gos)); // R13
    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        prog_go |=> !prog_go); // R13
    AST_GO_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|gos) |-> $past(wr_en && arr_sel)); // R5
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (read_mode && !(wr_en && arr_sel)) |=> read_mode); // R6
    AST_PROG_BUSY: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> !read_mode); // R3
    AST_SUSP_READ: assert property (@(posedge clk) disable iff (rst)
        suspend_go |-> read_mode); // R9
    AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (rst)
        resume_go |-> !read_mode); // R9
    AST_OPADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(op_addr) |-> (prog_go || sect_erase_go)); // R8
    AST_BYPASS_NOT_READ: assert property (@(posedge clk) disable iff (rst)
        bypass_on |-> !read_mode); // R11
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .arr_sel       (arr_sel),
    .prog_go       (prog_go),
    .chip_erase_go (chip_erase_go),
    .sect_erase_go (sect_erase_go),
    .suspend_go    (suspend_go),
    .resume_go     (resume_go),
    .op_addr       (op_addr),
    .read_mode     (read_mode),
    .bypass_on     (bypass_on)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, arr_sel = 1'b0, us_tick = 1'b0, op_done = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_go, chip_erase_go, sect_erase_go, suspend_go, resume_go;
    logic [15:0] op_addr;
    logic [7:0]  op_data;
    logic        read_mode, bypass_on;

    int checks = 0, fails = 0;
    int n_prog = 0, n_chip = 0, n_sect = 0, n_susp = 0, n_resm = 0;
    int exp_prog = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .arr_sel(arr_sel), .us_tick(us_tick), .op_done(op_done),
        .prog_go(prog_go), .chip_erase_go(chip_erase_go), .sect_erase_go(sect_erase_go),
        .suspend_go(suspend_go), .resume_go(resume_go), .op_addr(op_addr),
        .op_data(op_data), .read_mode(read_mode), .bypass_on(bypass_on)
    );

    always @(posedge clk) if (!rst) begin
        if (prog_go)       n_prog++;
        if (chip_erase_go) n_chip++;
        if (sect_erase_go) n_sect++;
        if (suspend_go)    n_susp++;
        if (resume_go)     n_resm++;
    end

    function automatic logic [15:0] at(input logic [3:0] hi, input logic [11:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic [7:0] not_key(input logic [7:0] d);
        return (d == 8'hAA) ? 8'hAB : d;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit s = 1'b1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; arr_sel = s;
        @(negedge clk);
        wr_en = 1'b0; arr_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk); us_tick = 1'b1;
            @(negedge clk); us_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic unlock(input logic [3:0] hi);
        wr(at(hi, 12'h555), 8'hAA);
        wr(at(hi, 12'hAAA), 8'h55);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        summary();
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(read_mode == 1'b1, "R1 read_mode", read_mode, 1);
        chk(bypass_on == 1'b0, "R1 bypass_on", bypass_on, 0);
        chk({prog_go, chip_erase_go, sect_erase_go, suspend_go, resume_go} == 5'b0,
            "R1 pulses", {prog_go, chip_erase_go, sect_erase_go, suspend_go, resume_go}, 0);

        // R3 plain program
        unlock(4'h0); wr(16'h0555, 8'hA0); wr(16'h0123, 8'h5A); exp_prog++;
        chk(prog_go == 1'b1, "R3 prog_go", prog_go, 1);
        chk(op_addr == 16'h0123, "R3 op_addr", op_addr, 16'h0123);
        chk(op_data == 8'h5A, "R3 op_data", op_data, 8'h5A);
        chk(read_mode == 1'b0, "R3 busy", read_mode, 0);
        idle(1);
        chk(prog_go == 1'b0, "R13 single cycle", prog_go, 0);
        done_pulse();
        chk(read_mode == 1'b1, "R10 done to read", read_mode, 1);

        // R2 upper bits ignored
        wr(16'hF555, 8'hAA); wr(16'h3AAA, 8'h55); wr(16'h9555, 8'hA0);
        wr(16'hE777, 8'hC3); exp_prog++;
        chk(prog_go == 1'b1 && op_addr == 16'hE777, "R2 upper bits", op_addr, 16'hE777);
        done_pulse();

        // R4 wrong unlock address, then rest of sequence ignored
        wr(16'h0555, 8'hAA); wr(16'h0AAB, 8'h55);
        chk(read_mode == 1'b1, "R4 bad addr", read_mode, 1);
        wr(16'h0AAA, 8'h55); wr(16'h0555, 8'hA0); wr(16'h0100, 8'h11); idle(2);
        chk(n_prog == exp_prog, "R4 no program", n_prog, exp_prog);
        // R4 wrong unlock data
        wr(16'h0555, 8'hAA); wr(16'h0AAA, 8'h54);
        chk(read_mode == 1'b1, "R4 bad data", read_mode, 1);
        // R4 unknown command
        unlock(4'h2); wr(16'h0555, 8'h77);
        chk(read_mode == 1'b1, "R4 bad command", read_mode, 1);

        // R5 write with select low ignored mid-sequence
        unlock(4'h0); wr(16'h0555, 8'hA0, 1'b0);
        chk(read_mode == 1'b0, "R5 still in sequence", read_mode, 1'b0);
        wr(16'h0555, 8'hA0); wr(16'h0200, 8'h22); exp_prog++;
        chk(prog_go == 1'b1 && op_data == 8'h22, "R5 sequence intact", op_data, 8'h22);
        done_pulse();

        // R6 timeout boundary: 80 ticks allowed
        ticks(150);
        wr(16'h0555, 8'hAA); ticks(80); wr(16'h0AAA, 8'h55); ticks(80);
        wr(16'h0555, 8'hA0); ticks(80); wr(16'h0300, 8'h33); exp_prog++;
        chk(prog_go == 1'b1 && op_addr == 16'h0300, "R6 80 ticks ok", op_addr, 16'h0300);
        ticks(100);
        chk(read_mode == 1'b0, "R6 no timeout while busy", read_mode, 0);
        done_pulse();
        // R6 81 ticks abort
        wr(16'h0555, 8'hAA); ticks(81);
        chk(read_mode == 1'b1, "R6 81 ticks abort", read_mode, 1);
        wr(16'h0AAA, 8'h55); wr(16'h0555, 8'hA0); wr(16'h0301, 8'h34); idle(2);
        chk(n_prog == exp_prog, "R6 aborted no program", n_prog, exp_prog);

        // R12 reset command
        wr(16'h0555, 8'hAA);
        chk(read_mode == 1'b0, "R12 left read", read_mode, 0);
        wr(16'h0AAA, 8'h55); wr(16'h0555, 8'hF0);
        chk(read_mode == 1'b1, "R12 back to read", read_mode, 1);
        wr(16'h0400, 8'h44); idle(2);
        chk(n_prog == exp_prog, "R12 no program", n_prog, exp_prog);

        // R7 whole-array erase, suspend ignored
        unlock(4'h1); wr(16'h1555, 8'h80); unlock(4'h5); wr(16'h6555, 8'h10);
        chk(chip_erase_go == 1'b1, "R7 chip_erase_go", chip_erase_go, 1);
        wr(16'h0000, 8'hB0); idle(2);
        chk(n_susp == 0 && n_chip == 1, "R9 no suspend on chip erase", n_susp, 0);
        chk(read_mode == 1'b0, "R9 chip erase still running", read_mode, 0);
        done_pulse();
        chk(read_mode == 1'b1, "R10 chip erase done", read_mode, 1);

        // R8 sector erase with suspend/resume
        unlock(4'h0); wr(16'h0555, 8'h80); unlock(4'h0); wr(16'h7123, 8'h30);
        chk(sect_erase_go == 1'b1, "R8 sect_erase_go", sect_erase_go, 1);
        chk(op_addr == 16'h7123, "R8 op_addr", op_addr, 16'h7123);
        wr(16'h0000, 8'h12);
        chk(read_mode == 1'b0 && op_addr == 16'h7123, "R9 other write ignored", read_mode, 0);
        wr(16'h0000, 8'hB0);
        chk(suspend_go == 1'b1 && read_mode == 1'b1, "R9 suspend", {suspend_go, read_mode}, 2'b11);
        wr(16'h0555, 8'hAA); ticks(100);
        chk(read_mode == 1'b1, "R9 suspended holds", read_mode, 1);
        wr(16'h0000, 8'h30);
        chk(resume_go == 1'b1 && read_mode == 1'b0, "R9 resume", {resume_go, read_mode}, 2'b10);
        done_pulse();
        chk(read_mode == 1'b1 && n_sect == 1, "R10 sector done", read_mode, 1);

        // R11 bypass
        unlock(4'h0); wr(16'h0555, 8'h20);
        chk(bypass_on == 1'b1 && read_mode == 1'b0, "R11 enter bypass", bypass_on, 1);
        ticks(100);
        wr(16'h0000, 8'hA0); wr(16'h5432, 8'h99); exp_prog++;
        chk(prog_go == 1'b1 && op_data == 8'h99, "R11 bypass program", op_data, 8'h99);
        done_pulse();
        chk(bypass_on == 1'b1 && read_mode == 1'b0, "R10 done back to bypass", bypass_on, 1);
        wr(16'h0000, 8'h90); wr(16'h0000, 8'h00);
        chk(bypass_on == 1'b0 && read_mode == 1'b1, "R11 exit bypass", bypass_on, 0);

        // R3 random program sequences with random upper bits and gaps
        for (int i = 0; i < 30; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom); d = 8'($urandom);
            wr(at(4'($urandom), 12'h555), 8'hAA); ticks($urandom_range(0, 80));
            wr(at(4'($urandom), 12'hAAA), 8'h55); ticks($urandom_range(0, 80));
            wr(at(4'($urandom), 12'h555), 8'hA0); ticks($urandom_range(0, 80));
            wr(a, d); exp_prog++;
            chk(prog_go == 1'b1 && op_addr == a && op_data == d, "R3 random program",
                {op_addr, op_data}, {a, d});
            done_pulse();
        end

        // R5 random noise in read mode
        for (int i = 0; i < 30; i++) begin
            logic s;
            logic [7:0] d;
            s = 1'($urandom);
            d = 8'($urandom);
            if (s) d = not_key(d);
            wr(16'($urandom), d, s);
            chk(read_mode == 1'b1, "R5 noise ignored", read_mode, 1);
        end
        idle(2);
        chk(n_prog == exp_prog, "R13 program count", n_prog, exp_prog);
        chk(n_chip == 1 && n_sect == 1 && n_susp == 1 && n_resm == 1, "R13 other counts",
            {n_chip[3:0], n_sect[3:0], n_susp[3:0], n_resm[3:0]}, 16'h1111);
        summary();
    end
endmodule